// File: doc/BRIEF.md
# SDRAM Bank Activation Timing Guard

This block watches the command lines going to an eight-bank DDR2-class SDRAM and rules on every command in the cycle it is presented. It decodes the activate, read, write, single-bank precharge and precharge-all commands from the select and strobe lines. It flags any command that breaks a bank-state rule or a row-timing rule, and it reports which rule was broken as a small error code. All timing limits arrive as configuration inputs counted in clock cycles, so one build serves every speed grade.

Each bank runs a two-state machine. In CLOSED, an accepted activate to the bank takes the transition OPEN_ON_ACT to OPEN. In OPEN, an accepted precharge of that bank, or an accepted precharge-all, takes the transition CLOSE_ON_PRE back to CLOSED. Every other case holds the state. Beside the state, each bank keeps a saturating count of cycles since its last activate and a countdown of remaining precharge time. A shared tracker keeps the ages of the four most recent accepted activates, which covers both the spacing between any two activates and the rolling four-activate window. The verdict is combinational. Only accepted commands change state, so a rejected command leaves every timer as it was.

Top module: `sdram_act_guard`

## Requirements
- R1: Commands are decoded with cs_n low as {ras_n,cas_n,we_n}: 011 activate, 101 read, 100 write, 010 precharge (addr[10]=1 means precharge-all), 111 no-op. cmd_chk is high only for activate, read, write, precharge and precharge-all. With cs_n high the command is ignored: cmd_chk=0, cmd_bad=0, and no state changes.
- R2: A read or write to a CLOSED bank is illegal with code 1. An accepted activate moves the bank to OPEN, and a read or write to it is then judged only by R9.
- R3: An activate to an OPEN bank is illegal with code 2. For an activate, the checks are ranked 2, then 7, then 3, then 4, then 5, and the highest-ranked failing check gives the code.
- R4: An activate to a bank fewer than cfg_trc cycles after that bank's previous activate is illegal with code 3.
- R5: An activate fewer than cfg_trrd cycles after the previous accepted activate to any bank is illegal with code 4.
- R6: An activate is illegal with code 5 when the fourth most recent accepted activate lies fewer than cfg_tfaw cycles back.
- R7: A precharge to an OPEN bank fewer than cfg_tras cycles after its activate is illegal with code 6. A precharge-all is illegal with code 6 if any OPEN bank breaks that limit.
- R8: An activate to a bank is illegal with code 7 until cfg_trp cycles have passed since the precharge that closed it. After a precharge-all the limit is cfg_trp + cfg_pall_extra.
- R9: A read or write to an OPEN bank is illegal with code 8 when the cycles since its activate plus cfg_al are fewer than cfg_trcd.
- R10: An illegal command changes no bank state, no timer and no activate history.
- R11: After reset all banks are CLOSED and every timing limit counts as met. A legal command reports cmd_bad=0 and code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 3 | Bank address |
| addr | input | 13 | Row address; bit 10 selects precharge-all |
| cfg_trc | input | 8 | Same-bank activate spacing, cycles |
| cfg_trrd | input | 8 | Any-bank activate spacing, cycles |
| cfg_tfaw | input | 8 | Four-activate window length, cycles |
| cfg_tras | input | 8 | Minimum activate-to-precharge, cycles |
| cfg_trp | input | 8 | Precharge-to-activate, cycles |
| cfg_trcd | input | 8 | Activate-to-read/write, cycles |
| cfg_al | input | 3 | Additive latency, 0 to 6 |
| cfg_pall_extra | input | 8 | Extra precharge time after precharge-all |
| cmd_chk | output | 1 | A checked command is present this cycle |
| cmd_bad | output | 1 | The present command is illegal |
| err_code | output | 4 | Rule broken (0 when legal) |

## Verification
An activate is judged in the same cycle by its own bank's state machine and timers and by the shared activate history, so a per-bank rule and a global rule can fail together. The stimulus table sets up such cycles on purpose. A refused activate arrives after only two cycles of spacing, while the fourth-last activate is still inside the window, so the spacing rule passes and the window rule must fire. A precharge-all closes banks whose activate ages differ, so the tRAS sweep over all banks and the later extended precharge countdown meet in the same sequence. Each verdict is judged against the expected code, which the fixed ranking of R3 makes unique.

// File: rtl/sag_pkg.sv
package sag_pkg;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_ACT,
        CMD_RD,
        CMD_WR,
        CMD_PRE,
        CMD_PALL,
        CMD_OTHER
    } sag_cmd_e;

    typedef enum logic [3:0] {
        ERR_NONE   = 4'd0,
        ERR_CLOSED = 4'd1,
        ERR_OPEN   = 4'd2,
        ERR_TRC    = 4'd3,
        ERR_TRRD   = 4'd4,
        ERR_TFAW   = 4'd5,
        ERR_TRAS   = 4'd6,
        ERR_TRP    = 4'd7,
        ERR_TRCD   = 4'd8
    } sag_err_e;

    typedef enum logic {
        BK_CLOSED,
        BK_OPEN
    } sag_bank_e;

endpackage

// File: rtl/sag_decode.sv
module sag_decode
    import sag_pkg::*;
(
    input  logic     cs_n,
    input  logic     ras_n,
    input  logic     cas_n,
    input  logic     we_n,
    input  logic     a10,
    output sag_cmd_e cmd
);

    always_comb begin
        cmd = CMD_NOP;
        if (!cs_n) begin
            unique case ({ras_n, cas_n, we_n})
                3'b111:  cmd = CMD_NOP;
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b010:  cmd = a10 ? CMD_PALL : CMD_PRE;
                default: cmd = CMD_OTHER;
            endcase
        end
    end

endmodule

// File: rtl/sag_bank.sv
module sag_bank
    import sag_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          act_go,
    input  logic          pre_go,
    input  logic [TW:0]   pre_need,
    output logic          is_open,
    output logic [TW-1:0] act_age,
    output logic [TW:0]   rp_left
);

    localparam logic [TW-1:0] AGE_MAX = {TW{1'b1}};

    sag_bank_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BK_CLOSED: if (act_go) state_d = BK_OPEN;
            BK_OPEN:   if (pre_go) state_d = BK_CLOSED;
            default:   state_d = BK_CLOSED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BK_CLOSED;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_age <= AGE_MAX;
            rp_left <= '0;
        end else begin
            if (act_go)                 act_age <= {{(TW-1){1'b0}}, 1'b1};
            else if (act_age != AGE_MAX) act_age <= act_age + 1'b1;

            if (pre_go)                 rp_left <= (pre_need == '0) ? '0 : pre_need - 1'b1;
            else if (rp_left != '0)     rp_left <= rp_left - 1'b1;
        end
    end

    assign is_open = (state_q == BK_OPEN);

    a_r3_act_only_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
        act_go |-> !is_open);
    a_r2_open_after_act: assert property (@(posedge clk) disable iff (!rst_n)
        act_go |=> is_open);
    a_r8_act_after_precharge: assert property (@(posedge clk) disable iff (!rst_n)
        act_go |-> (rp_left == '0));

endmodule

// File: rtl/sag_faw.sv
module sag_faw #(
    parameter int TW    = 8,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [TW-1:0] t_faw,
    output logic [TW-1:0] newest_age,
    output logic [TW-1:0] oldest_age
);

    localparam logic [TW-1:0] AGE_MAX = {TW{1'b1}};

    logic [TW-1:0] age_q [DEPTH];

    function automatic logic [TW-1:0] sat_inc(input logic [TW-1:0] v);
        return (v == AGE_MAX) ? v : v + 1'b1;
    endfunction

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    age_q[i] <= AGE_MAX;
                end else if (push) begin
                    if (i == 0) age_q[i] <= {{(TW-1){1'b0}}, 1'b1};
                    else        age_q[i] <= sat_inc(age_q[(i == 0) ? 0 : i-1]);
                end else begin
                    age_q[i] <= sat_inc(age_q[i]);
                end
            end
        end
    endgenerate

    assign newest_age = age_q[0];
    assign oldest_age = age_q[DEPTH-1];

    a_r6_window_respected: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (oldest_age >= t_faw));
    a_r10_history_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!push && newest_age != AGE_MAX) |=> (newest_age == $past(newest_age) + 1'b1));

endmodule

// File: rtl/sdram_act_guard.sv
module sdram_act_guard
    import sag_pkg::*;
#(
    parameter int BANKS = 8,
    parameter int TW    = 8,
    parameter int WIN   = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_n,
    input  logic        ras_n,
    input  logic        cas_n,
    input  logic        we_n,
    input  logic [2:0]  ba,
    input  logic [12:0] addr,
    input  logic [7:0]  cfg_trc,
    input  logic [7:0]  cfg_trrd,
    input  logic [7:0]  cfg_tfaw,
    input  logic [7:0]  cfg_tras,
    input  logic [7:0]  cfg_trp,
    input  logic [7:0]  cfg_trcd,
    input  logic [2:0]  cfg_al,
    input  logic [7:0]  cfg_pall_extra,
    output logic        cmd_chk,
    output logic        cmd_bad,
    output logic [3:0]  err_code
);

    localparam int BAW = $clog2(BANKS);

    sag_cmd_e        cmd;
    sag_err_e        err;
    logic [BANKS-1:0] bk_open;
    logic [TW-1:0]   bk_age [BANKS];
    logic [TW:0]     bk_rp  [BANKS];
    logic [BANKS-1:0] act_go, pre_go;
    logic [TW:0]     pre_need;
    logic [TW-1:0]   newest_age, oldest_age;
    logic            accept;
    logic            unused_row;

    assign unused_row = ^{addr[12:11], addr[9:0]};

    sag_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .a10   (addr[10]),
        .cmd   (cmd)
    );

    always_comb begin
        err = ERR_NONE;
        unique case (cmd)
            CMD_ACT: begin
                if (bk_open[ba[BAW-1:0]])                err = ERR_OPEN;
                else if (bk_rp[ba[BAW-1:0]] != '0)       err = ERR_TRP;
                else if (bk_age[ba[BAW-1:0]] < cfg_trc)  err = ERR_TRC;
                else if (newest_age < cfg_trrd)          err = ERR_TRRD;
                else if (oldest_age < cfg_tfaw)          err = ERR_TFAW;
            end
            CMD_RD, CMD_WR: begin
                if (!bk_open[ba[BAW-1:0]]) err = ERR_CLOSED;
                else if (({1'b0, bk_age[ba[BAW-1:0]]} + {{(TW-2){1'b0}}, cfg_al}) < {1'b0, cfg_trcd})
                    err = ERR_TRCD;
            end
            CMD_PRE: begin
                if (bk_open[ba[BAW-1:0]] && bk_age[ba[BAW-1:0]] < cfg_tras) err = ERR_TRAS;
            end
            CMD_PALL: begin
                for (int i = 0; i < BANKS; i++)
                    if (bk_open[i] && bk_age[i] < cfg_tras) err = ERR_TRAS;
            end
            default: err = ERR_NONE;
        endcase
    end

    assign cmd_chk  = (cmd != CMD_NOP) && (cmd != CMD_OTHER);
    assign cmd_bad  = (err != ERR_NONE);
    assign err_code = err;
    assign accept   = cmd_chk && !cmd_bad;
    assign pre_need = (cmd == CMD_PALL) ? ({1'b0, cfg_trp} + {1'b0, cfg_pall_extra})
                                        : {1'b0, cfg_trp};

    generate
        for (genvar b = 0; b < BANKS; b++) begin : g_bank
            assign act_go[b] = accept && (cmd == CMD_ACT) && (ba[BAW-1:0] == b[BAW-1:0]);
            assign pre_go[b] = accept && ((cmd == CMD_PALL) ||
                               ((cmd == CMD_PRE) && (ba[BAW-1:0] == b[BAW-1:0]) && bk_open[b]));
            sag_bank #(.TW(TW)) u_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .act_go   (act_go[b]),
                .pre_go   (pre_go[b]),
                .pre_need (pre_need),
                .is_open  (bk_open[b]),
                .act_age  (bk_age[b]),
                .rp_left  (bk_rp[b])
            );
        end
    endgenerate

    sag_faw #(.TW(TW), .DEPTH(WIN)) u_faw (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (|act_go),
        .t_faw      (cfg_tfaw),
        .newest_age (newest_age),
        .oldest_age (oldest_age)
    );

    a_r1_deselect_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (!cmd_chk && !cmd_bad && act_go == '0 && pre_go == '0));
    a_r5_spacing_any_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (act_go != '0) |-> (newest_age >= cfg_trrd));
    a_r4_spacing_same_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (act_go != '0) |-> (bk_age[ba[BAW-1:0]] >= cfg_trc));
    a_r10_one_act_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(act_go));

endmodule

// File: tb/sim_sdram_act_guard.sv
module sim_sdram_act_guard;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 37;
    // op codes local to the bench: 0 nop,1 act,2 rd,3 wr,4 pre,5 pall,6 deselected act
    localparam logic [9:0] VEC [NVEC] = '{
        {3'd1,3'd0,4'd0}, {3'd2,3'd0,4'd8}, {3'd1,3'd0,4'd2}, {3'd2,3'd0,4'd0},
        {3'd1,3'd1,4'd0}, {3'd1,3'd2,4'd4}, {3'd1,3'd2,4'd0}, {3'd4,3'd2,4'd6},
        {3'd1,3'd3,4'd0}, {3'd2,3'd5,4'd1}, {3'd1,3'd4,4'd5}, {3'd0,3'd0,4'd0},
        {3'd1,3'd4,4'd0}, {3'd4,3'd0,4'd0}, {3'd1,3'd0,4'd7}, {3'd1,3'd0,4'd7},
        {3'd1,3'd0,4'd0}, {3'd3,3'd0,4'd8}, {3'd4,3'd0,4'd0}, {3'd0,3'd0,4'd0},
        {3'd0,3'd0,4'd0}, {3'd1,3'd0,4'd3}, {3'd1,3'd0,4'd0}, {3'd2,3'd3,4'd0},
        {3'd5,3'd0,4'd0}, {3'd0,3'd0,4'd0}, {3'd0,3'd0,4'd0}, {3'd0,3'd0,4'd0},
        {3'd1,3'd5,4'd7}, {3'd1,3'd5,4'd0}, {3'd2,3'd0,4'd1}, {3'd1,3'd6,4'd0},
        {3'd6,3'd6,4'd0}, {3'd1,3'd7,4'd0}, {3'd5,3'd0,4'd6}, {3'd5,3'd0,4'd0},
        {3'd3,3'd7,4'd1}
    };

    logic clk = 1'b0;
    logic rst_n;
    logic cs_n, ras_n, cas_n, we_n;
    logic [2:0]  ba;
    logic [12:0] addr;
    logic [7:0]  cfg_trc, cfg_trrd, cfg_tfaw, cfg_tras, cfg_trp, cfg_trcd, cfg_pall_extra;
    logic [2:0]  cfg_al;
    logic        cmd_chk, cmd_bad;
    logic [3:0]  err_code;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_act_guard u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr), .cfg_trc(cfg_trc), .cfg_trrd(cfg_trrd), .cfg_tfaw(cfg_tfaw),
        .cfg_tras(cfg_tras), .cfg_trp(cfg_trp), .cfg_trcd(cfg_trcd), .cfg_al(cfg_al),
        .cfg_pall_extra(cfg_pall_extra), .cmd_chk(cmd_chk), .cmd_bad(cmd_bad), .err_code(err_code)
    );

    function automatic string req_of(input logic [2:0] op, input logic [3:0] code);
        case (code)
            4'd1: return "R2";
            4'd2: return "R3";
            4'd3: return "R4";
            4'd4: return "R5";
            4'd5: return "R6";
            4'd6: return "R7";
            4'd7: return "R8";
            4'd8: return "R9";
            default: return (op == 3'd0 || op == 3'd6) ? "R1" : "R11";
        endcase
    endfunction

    task automatic drive(input logic [2:0] op, input logic [2:0] bank);
        @(negedge clk);
        ba = bank;
        addr = 13'h0;
        cs_n = 1'b0;
        case (op)
            3'd1: {ras_n, cas_n, we_n} = 3'b011;
            3'd2: {ras_n, cas_n, we_n} = 3'b101;
            3'd3: {ras_n, cas_n, we_n} = 3'b100;
            3'd4: {ras_n, cas_n, we_n} = 3'b010;
            3'd5: begin {ras_n, cas_n, we_n} = 3'b010; addr[10] = 1'b1; end
            3'd6: begin {ras_n, cas_n, we_n} = 3'b011; cs_n = 1'b1; end
            default: {ras_n, cas_n, we_n} = 3'b111;
        endcase
        #1;
    endtask

    task automatic check(input string req, input logic [2:0] op, input logic [3:0] code);
        logic exp_chk;
        exp_chk = (op >= 3'd1 && op <= 3'd5);
        n_chk++;
        if (cmd_chk !== exp_chk || cmd_bad !== (code != 4'd0) || err_code !== code) begin
            n_bad++;
            $display("FAIL %s op=%0d: chk/bad/code=%b/%b/%0d expected %b/%b/%0d",
                     req, op, cmd_chk, cmd_bad, err_code, exp_chk, (code != 4'd0), code);
        end
    endtask

    task automatic step(input string req, input logic [2:0] op, input logic [2:0] bank,
                        input logic [3:0] code);
        drive(op, bank);
        check(req, op, code);
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; ba = '0; addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        cfg_trc = 8'd6; cfg_trrd = 8'd2; cfg_tfaw = 8'd12; cfg_tras = 8'd2;
        cfg_trp = 8'd3; cfg_trcd = 8'd3; cfg_al = 3'd0; cfg_pall_extra = 8'd2;
        do_reset();
        // R11: idle outputs after reset
        step("R11", 3'd0, 3'd0, 4'd0);

        // main table; rejected commands at rows 5 and 10 are followed by accepted
        // commands whose verdicts depend on R10 (no state change on rejection)
        for (int i = 0; i < NVEC; i++)
            step(req_of(VEC[i][9:7], VEC[i][3:0]), VEC[i][9:7], VEC[i][6:4], VEC[i][3:0]);

        // R9: additive latency lets a read through earlier
        do_reset();
        cfg_al = 3'd1;
        step("R11", 3'd1, 3'd1, 4'd0);
        step("R9", 3'd2, 3'd1, 4'd8);
        step("R9", 3'd2, 3'd1, 4'd0);
        cfg_al = 3'd2;
        step("R11", 3'd1, 3'd2, 4'd0);
        step("R9", 3'd3, 3'd2, 4'd0);

        // R10: a refused precharge leaves the bank open
        do_reset();
        cfg_al = 3'd1;
        step("R11", 3'd1, 3'd3, 4'd0);
        step("R7", 3'd4, 3'd3, 4'd6);
        step("R10", 3'd2, 3'd3, 4'd0);
        step("R10", 3'd1, 3'd3, 4'd2);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule